// File: doc/BRIEF.md
# Configuration Header Register Responder

This block is the target side of the standard Type 0 configuration header of a single-function peripheral. It answers configuration reads and writes from a simple register port. A request is claimed only when the select input is high and the function number is zero. For any other function number the request goes unclaimed, so the host sees no acknowledge and can report that function as absent. The block holds fixed identity words (vendor/device and subsystem vendor/subsystem), a small command register, the cache line size and latency timer, and one 32-bit memory base address register.

The base address register stores only the bits above the window size. An all-ones write therefore reads back as a size mask, with the type bits in the low nibble. Configuration software uses this handshake to size the window and then writes the assigned base. Two qualified outputs go to the rest of the peripheral. The first is a memory-decode hit for an incoming address, gated by the memory-space enable. The second is a permit for write-and-invalidate, which needs both its command enable and a nonzero cache line size. Every programmable value returns to zero on reset, so software must program it again after each power-up.

Top module: `cfg_hdr_resp`

## Requirements
- R1: After reset, `cfg_ack`, `cfg_rdata`, `mem_hit` and `mwi_ok` are 0. The command word reads 0. The base address register reads back only its type bits (bit 3 = prefetchable parameter). A later reset returns every programmed value to this state.
- R2: A request with `cfg_sel`=1 and `cfg_func`=0 raises `cfg_ack` exactly one cycle later. With any other function number there is no acknowledge, read data stays 0 and a write has no effect.
- R3: Dword 0 reads {device ID, vendor ID}, in bits 31:16 and 15:0. Dword 11 reads {subsystem ID, subsystem vendor ID}. Writes to either dword are ignored.
- R4: After all ones is written to dword 4, it reads back as ~(2^BAR_LOG2 − 1) with bits 3:0 replaced by {prefetchable, 0, 0, 0}. Bit 0 = 0 marks memory space, and bits 2:1 = 00 mark 32-bit decode.
- R5: Dword 4 keeps only the written bits 31:BAR_LOG2 as the window base. Lower written bits are discarded.
- R6: Writes apply per byte lane: `cfg_be[n]` enables bits 8n+7:8n, and lanes that are not enabled keep their value.
- R7: Command (dword 1, bits 15:0) has three writable bits: bit 1 memory-space enable, bit 2 bus-master enable and bit 4 write-and-invalidate enable. All other bits of dword 1 read 0.
- R8: Dword 3 holds the cache line size in bits 7:0 and the latency timer in bits 15:8, both writable. Header type (bits 23:16) and self-test (bits 31:24) always read 0.
- R9: `mwi_ok` is 1 exactly when command bit 4 is set and the cache line size is nonzero. It takes effect from the cycle in which the write is acknowledged.
- R10: `mem_hit` is 1 only when command bit 1 is set and `mem_addr` bits 31:BAR_LOG2 equal the stored base.
- R11: A claimed read of any dword other than 0, 1, 3, 4 and 11 is acknowledged and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Configuration request strobe, one cycle per request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_func | input | 3 | Function number of the request |
| cfg_idx | input | 6 | Dword index within the header |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid while `cfg_ack` is high, otherwise 0 |
| cfg_ack | output | 1 | Acknowledge, one cycle after a claimed request |
| mem_addr | input | 32 | Address to decode against the memory window |
| mem_hit | output | 1 | Address falls in the enabled window |
| mwi_ok | output | 1 | Write-and-invalidate permitted |

## Verification
A claimed request is acknowledged on the clock edge that samples it. Read data arrives on that same edge, so both are due one cycle after the strobe. The bench drives each request on a falling edge and samples acknowledge and data on the next falling edge. `mwi_ok` and `mem_hit` are combinational from registers written at that edge, so they are checked at the same falling edge as the write acknowledge. The effect of `mem_addr` on `mem_hit` is checked half a cycle after the address changes, with no clock needed. The checks for ignored writes and unclaimed functions always read the affected dword back through the register port.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int unsigned IDX_W = 6;
  localparam logic [IDX_W-1:0] DW_ID  = 6'd0;
  localparam logic [IDX_W-1:0] DW_CMD = 6'd1;
  localparam logic [IDX_W-1:0] DW_CLS = 6'd3;
  localparam logic [IDX_W-1:0] DW_BAR = 6'd4;
  localparam logic [IDX_W-1:0] DW_SUB = 6'd11;

  // merge write data into an old word under per-lane enables
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_w;
    for (int l = 0; l < 4; l++)
      if (be[l]) r[8*l +: 8] = new_w[8*l +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfg_cmd_regs.sv
module cfg_cmd_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_cls,
  input  logic [3:0]  be,
  input  logic [2:0]  cmd_bits,   // {mwi_en, master_en, mem_en} from write data
  input  logic [7:0]  cls_byte,
  input  logic [7:0]  lat_byte,
  output logic [15:0] cmd_word,
  output logic [7:0]  cls_q,
  output logic [7:0]  lat_q,
  output logic        mem_en,
  output logic        mwi_ok
);
  logic [2:0] cmd_q, cmd_d;
  logic [7:0] cls_d, lat_d;
  logic       cmd_ce, cls_ce, lat_ce;

  always_comb begin
    cmd_ce = wr_cmd & be[0];
    cls_ce = wr_cls & be[0];
    lat_ce = wr_cls & be[1];
    cmd_d  = cmd_bits;
    cls_d  = cls_byte;
    lat_d  = lat_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cls_q <= '0;
      lat_q <= '0;
    end else begin
      if (cmd_ce) cmd_q <= cmd_d;
      if (cls_ce) cls_q <= cls_d;
      if (lat_ce) lat_q <= lat_d;
    end
  end

  assign cmd_word = {11'd0, cmd_q[2], 1'b0, cmd_q[1], cmd_q[0], 1'b0};
  assign mem_en   = cmd_q[0];
  assign mwi_ok   = cmd_q[2] & (cls_q != 8'd0);
endmodule

// File: rtl/cfg_bar.sv
module cfg_bar #(
  parameter int unsigned BAR_LOG2 = 12,
  parameter bit          PREF     = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_bar,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        mem_en,
  input  logic [31:0] mem_addr,
  output logic [31:0] bar_rd,
  output logic        hit
);
  import cfg_hdr_pkg::*;
  localparam int unsigned BASE_W = 32 - BAR_LOG2;
  localparam logic [31:0] WIN_MASK = ~((32'd1 << BAR_LOG2) - 32'd1);
  localparam logic [31:0] TYPE_BITS = {28'd0, PREF, 3'b000};

  logic [BASE_W-1:0] base_q, base_d;
  logic [31:0]       full_w, merged;
  logic              base_ce;

  assign full_w = {base_q, {BAR_LOG2{1'b0}}};

  always_comb begin
    merged  = lane_merge(full_w, wdata, be);
    base_d  = merged[31:BAR_LOG2];
    base_ce = wr_bar & (|be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_ce) base_q <= base_d;
  end

  assign bar_rd = full_w | TYPE_BITS;
  assign hit    = mem_en & (((mem_addr ^ full_w) & WIN_MASK) == 32'd0);
endmodule

// File: rtl/cfg_hdr_resp.sv
module cfg_hdr_resp #(
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID = 16'h7E21,
  parameter logic [15:0] SUB_VID   = 16'h3C4D,
  parameter logic [15:0] SUB_ID    = 16'h0102,
  parameter int unsigned BAR_LOG2  = 12,
  parameter bit          BAR_PREF  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_func,
  input  logic [5:0]  cfg_idx,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_ack,
  input  logic [31:0] mem_addr,
  output logic        mem_hit,
  output logic        mwi_ok
);
  import cfg_hdr_pkg::*;

  logic        claim, wr_hit, rd_hit;
  logic [15:0] cmd_word;
  logic [7:0]  cls_q, lat_q;
  logic        mem_en;
  logic [31:0] bar_rd;
  logic [31:0] mux_d, rdata_d;
  logic        ack_d;

  assign claim  = cfg_sel & (cfg_func == 3'd0);
  assign wr_hit = claim & cfg_wr;
  assign rd_hit = claim & ~cfg_wr;

  cfg_cmd_regs u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (wr_hit & (cfg_idx == DW_CMD)),
    .wr_cls   (wr_hit & (cfg_idx == DW_CLS)),
    .be       (cfg_be),
    .cmd_bits ({cfg_wdata[4], cfg_wdata[2], cfg_wdata[1]}),
    .cls_byte (cfg_wdata[7:0]),
    .lat_byte (cfg_wdata[15:8]),
    .cmd_word (cmd_word),
    .cls_q    (cls_q),
    .lat_q    (lat_q),
    .mem_en   (mem_en),
    .mwi_ok   (mwi_ok)
  );

  cfg_bar #(.BAR_LOG2(BAR_LOG2), .PREF(BAR_PREF)) u_bar (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_bar   (wr_hit & (cfg_idx == DW_BAR)),
    .be       (cfg_be),
    .wdata    (cfg_wdata),
    .mem_en   (mem_en),
    .mem_addr (mem_addr),
    .bar_rd   (bar_rd),
    .hit      (mem_hit)
  );

  always_comb begin
    unique case (cfg_idx)
      DW_ID:   mux_d = {DEVICE_ID, VENDOR_ID};
      DW_CMD:  mux_d = {16'd0, cmd_word};
      DW_CLS:  mux_d = {8'd0, 8'd0, lat_q, cls_q};
      DW_BAR:  mux_d = bar_rd;
      DW_SUB:  mux_d = {SUB_ID, SUB_VID};
      default: mux_d = 32'd0;
    endcase
    rdata_d = rd_hit ? mux_d : 32'd0;
    ack_d   = claim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ack   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      cfg_ack   <= ack_d;
      cfg_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0,
  parameter bit          BAR_PREF  = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_sel,
  input logic        cfg_wr,
  input logic [2:0]  cfg_func,
  input logic [5:0]  cfg_idx,
  input logic [31:0] cfg_rdata,
  input logic        cfg_ack,
  input logic [31:0] mem_addr,
  input logic        mem_hit,
  input logic        mwi_ok
);
  logic claimed, cfg_wr_any;
  assign claimed    = cfg_sel & (cfg_func == 3'd0);
  assign cfg_wr_any = claimed & cfg_wr;

  // R2: acknowledge exactly one cycle after a claimed request
  a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    claimed |=> cfg_ack);
  // R2: no acknowledge without a claimed request
  a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !claimed |=> !cfg_ack);
  // R2: read data is quiet when nothing is acknowledged
  a_r2_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ack |-> cfg_rdata == 32'd0);
  // R3: identity dword
  a_r3_id_word: assert property (@(posedge clk) disable iff (!rst_n)
    (claimed && !cfg_wr && cfg_idx == 6'd0) |=> cfg_rdata == {DEVICE_ID, VENDOR_ID});
  // R4: type bits of the address register
  a_r4_bar_type: assert property (@(posedge clk) disable iff (!rst_n)
    (claimed && !cfg_wr && cfg_idx == 6'd4) |=> cfg_rdata[3:0] == {BAR_PREF, 3'b000});
  // R9: the permit only turns on after a command or cache-line write
  a_r9_mwi_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mwi_ok) |-> $past(cfg_wr_any && (cfg_idx == 6'd1 || cfg_idx == 6'd3)));
  // R10: a hit appears only after a command/BAR write or an address change
  a_r10_hit_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_hit) |-> ($past(cfg_wr_any && (cfg_idx == 6'd1 || cfg_idx == 6'd4))
                        || !$stable(mem_addr)));
endmodule

bind cfg_hdr_resp cfg_hdr_chk #(
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .BAR_PREF(BAR_PREF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
  .cfg_func(cfg_func), .cfg_idx(cfg_idx), .cfg_rdata(cfg_rdata),
  .cfg_ack(cfg_ack), .mem_addr(mem_addr), .mem_hit(mem_hit), .mwi_ok(mwi_ok)
);

// File: tb/sim_cfg_hdr_resp.sv
module sim_cfg_hdr_resp;
  localparam logic [15:0] VID  = 16'hA5C3;
  localparam logic [15:0] DID  = 16'h7E21;
  localparam logic [15:0] SVID = 16'h3C4D;
  localparam logic [15:0] SID  = 16'h0102;
  localparam int unsigned LOG2 = 12;
  localparam bit          PREF = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_sel, cfg_wr;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_idx;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr;
  logic        cfg_ack, mem_hit, mwi_ok;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cfg_hdr_resp #(
    .VENDOR_ID(VID), .DEVICE_ID(DID), .SUB_VID(SVID), .SUB_ID(SID),
    .BAR_LOG2(LOG2), .BAR_PREF(PREF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_func(cfg_func), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack),
    .mem_addr(mem_addr), .mem_hit(mem_hit), .mwi_ok(mwi_ok)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one request; returns ack and data sampled one cycle later
  task automatic xfer(input bit wr, input logic [2:0] fn, input logic [5:0] idx,
                      input logic [3:0] be, input logic [31:0] wd,
                      output logic ack, output logic [31:0] rd);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_wr = wr; cfg_func = fn; cfg_idx = idx;
    cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    ack = cfg_ack; rd = cfg_rdata;
    cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = '0;
  endtask

  task automatic wr0(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] wd);
    logic a; logic [31:0] r;
    xfer(1'b1, 3'd0, idx, be, wd, a, r);
  endtask

  task automatic rd0(input logic [5:0] idx, output logic [31:0] r);
    logic a;
    xfer(1'b0, 3'd0, idx, 4'h0, 32'd0, a, r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset(input string tag);
    logic [31:0] r;
    chk({tag, " ack"}, {31'd0, cfg_ack}, 32'd0);
    chk({tag, " rdata"}, cfg_rdata, 32'd0);
    chk({tag, " hit"}, {31'd0, mem_hit}, 32'd0);
    chk({tag, " mwi"}, {31'd0, mwi_ok}, 32'd0);
    rd0(6'd1, r); chk({tag, " cmd"}, r, 32'd0);
    rd0(6'd3, r); chk({tag, " cls"}, r, 32'd0);
    rd0(6'd4, r); chk({tag, " bar"}, r, {28'd0, PREF, 3'b000});
  endtask

  task automatic t_ids();
    logic [31:0] r;
    rd0(6'd0, r);  chk("R3 id", r, {DID, VID});
    rd0(6'd11, r); chk("R3 sub", r, {SID, SVID});
    wr0(6'd0, 4'hF, 32'hFFFF_FFFF);
    wr0(6'd11, 4'hF, 32'h0000_0000);
    rd0(6'd0, r);  chk("R3 id after write", r, {DID, VID});
    rd0(6'd11, r); chk("R3 sub after write", r, {SID, SVID});
  endtask

  task automatic t_func();
    logic a; logic [31:0] r;
    xfer(1'b0, 3'd0, 6'd0, 4'h0, 32'd0, a, r);
    chk("R2 ack func0", {31'd0, a}, 32'd1);
    xfer(1'b0, 3'd3, 6'd0, 4'h0, 32'd0, a, r);
    chk("R2 no ack func3", {31'd0, a}, 32'd0);
    chk("R2 data func3", r, 32'd0);
    xfer(1'b1, 3'd2, 6'd3, 4'hF, 32'h0000_0010, a, r);
    chk("R2 no ack write func2", {31'd0, a}, 32'd0);
    rd0(6'd3, r); chk("R2 write func2 ignored", r, 32'd0);
  endtask

  task automatic t_bar();
    logic [31:0] r;
    wr0(6'd4, 4'hF, 32'hFFFF_FFFF);
    rd0(6'd4, r); chk("R4 size mask", r, 32'hFFFF_F000 | {28'd0, PREF, 3'b000});
    wr0(6'd4, 4'hF, 32'h1234_5FFF);
    rd0(6'd4, r); chk("R5 base", r, 32'h1234_5000 | {28'd0, PREF, 3'b000});
    wr0(6'd4, 4'b1000, 32'hAB00_0000);
    rd0(6'd4, r); chk("R6 top lane", r, 32'hAB34_5000 | {28'd0, PREF, 3'b000});
  endtask

  task automatic t_cmd_cls();
    logic [31:0] r;
    wr0(6'd1, 4'hF, 32'hFFFF_FFFF);
    rd0(6'd1, r); chk("R7 cmd mask", r, 32'h0000_0016);
    wr0(6'd1, 4'hF, 32'h0);
    rd0(6'd1, r); chk("R7 cmd clear", r, 32'h0);
    wr0(6'd3, 4'hF, 32'hFFFF_4020);
    rd0(6'd3, r); chk("R8 cls/lat", r, 32'h0000_4020);
    wr0(6'd3, 4'b0010, 32'h0000_5577);
    rd0(6'd3, r); chk("R6 lane1 only", r, 32'h0000_5520);
    rd0(6'd2, r);  chk("R11 dword2", r, 32'h0);
    rd0(6'd5, r);  chk("R11 dword5", r, 32'h0);
    rd0(6'd63, r); chk("R11 dword63", r, 32'h0);
  endtask

  task automatic t_mwi();
    wr0(6'd3, 4'b0001, 32'h0);
    wr0(6'd1, 4'h1, 32'h0000_0010);
    chk("R9 cls zero", {31'd0, mwi_ok}, 32'd0);
    wr0(6'd3, 4'b0001, 32'h0000_0010);
    chk("R9 enabled", {31'd0, mwi_ok}, 32'd1);
    wr0(6'd1, 4'h1, 32'h0);
    chk("R9 cmd off", {31'd0, mwi_ok}, 32'd0);
  endtask

  task automatic t_hit();
    @(negedge clk); mem_addr = 32'hAB34_5010;
    @(posedge clk); @(negedge clk);
    chk("R10 mem disabled", {31'd0, mem_hit}, 32'd0);
    wr0(6'd1, 4'h1, 32'h0000_0002);
    chk("R10 enabled in window", {31'd0, mem_hit}, 32'd1);
    mem_addr = 32'hAB34_6000; #10;
    chk("R10 above window", {31'd0, mem_hit}, 32'd0);
    mem_addr = 32'hAB34_5FFF; #10;
    chk("R10 top of window", {31'd0, mem_hit}, 32'd1);
    mem_addr = 32'hAB34_4FFF; #10;
    chk("R10 below window", {31'd0, mem_hit}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_func = 3'd0;
    cfg_idx = '0; cfg_be = '0; cfg_wdata = '0; mem_addr = '0;
    do_reset();
    t_reset("R1");
    t_ids();
    t_func();
    t_bar();
    t_cmd_cls();
    t_mwi();
    t_hit();
    do_reset();
    t_reset("R1 rereset");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule